// File: doc/BRIEF.md
# Dynamic Register-File Refresh Sequencer

This block models a small dynamic storage array for a 4-bit microcontroller bus. The array has twenty rows: sixteen main rows and four status rows. Each row is sixteen bits wide and holds one 4-bit character for each of four registers. Storage is never read or written directly. Every operation goes through three steps on the row's column lines: the lines are charged, the addressed row is sensed onto them, and the row is written back from them. An external timing unit marks each step with a one-clock strobe.

There are two strobe sequences:

- **Refresh:** `rf_pre`, `rf_sense`, `rf_restore`. It visits the row chosen by a free-running 5-bit counter that counts down.
- **Access:** `ac_pre`, `ac_sense`, `ac_drive`, `ac_commit`. It reads or writes the row named by the decoded bus command. The command inputs are latched at the sense step.

A charged column line stands for logic 0. While reset is held, sensing is blocked, so every write-back stores zeros. Running the refresh sequence under reset therefore clears the whole array.

A small sequencer tracks where each sequence has reached. It has six states:

| State | Entered on | Left on |
|---|---|---|
| `S_IDLE` | power-up, or any strobe out of order | a charge strobe |
| `S_RF_PRE` | `rf_pre`, from any state | `rf_sense` goes to `S_RF_SENSED`; any other strobe to `S_IDLE` |
| `S_RF_SENSED` | `rf_sense` | any strobe goes to `S_IDLE`; `rf_restore` also writes the row back |
| `S_AC_PRE` | `ac_pre`, from any state | `ac_sense` goes to `S_AC_SENSED`; any other strobe to `S_IDLE` |
| `S_AC_SENSED` | `ac_sense` | `ac_drive` goes to `S_AC_DRIVEN`; `ac_commit` writes and goes to `S_IDLE`; others to `S_IDLE` |
| `S_AC_DRIVEN` | `ac_drive` | any strobe goes to `S_IDLE`; `ac_commit` also writes |

Top module: `drf_refresh_seq`

## Requirements
- R1: At most one of the seven step strobes is high in any cycle. Either charge strobe (`rf_pre` or `ac_pre`) sets all sixteen column lines to the charged level, which reads as logic 0.
- R2: On `rf_sense` following `rf_pre`, the counter's row is sensed. On the `rf_restore` that follows, that row is written back unchanged, so stored data survives any number of refresh passes. The counter decrements by one on each write-back, wraps from 0 to 31, and otherwise holds.
- R3: Row selection works as follows:
  - A counter value with bit 4 clear selects main row `cnt[3:0]`.
  - A counter value with bit 4 set selects status row `cnt[1:0]`; bits 3:2 are ignored.
  - An access with `stat_sel`=1 selects status row `stat_idx` and ignores `chr_addr`.
  - An access with `stat_sel`=0 selects main row `chr_addr`.
- R4: `rd_oe` is high only in the `ac_drive` cycle of an access sensed with `rd_cmd`=1. In that cycle `rd_data` carries the nibble of register `reg_sel` as sensed. At all other times `rd_oe` and `rd_data` are 0.
- R5: An `ac_commit` after a write access stores `bus_in` into the nibble of the latched register. The other three nibbles of the row are rewritten with their sensed values.
- R6: While `rst` is high, sensing is blocked. Thirty-two refresh sequences under reset leave every nibble of all twenty rows at 0.
- R7: While `rst` is high, `rd_oe` stays 0. A write commit stores zeros into the row instead of the bus value.
- R8: A write-back happens only when the matching sense step came before it in the same sequence. An `ac_commit` that follows `ac_pre` with no `ac_sense` leaves the array unchanged, and so does an `rf_restore` that follows `rf_pre` with no `rf_sense`.
- R9: Row, register and command are captured at `ac_sense`. Changing `reg_sel` or `chr_addr` after that step has no effect on the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset; blocks sensing and bus gating |
| rf_pre | input | 1 | Refresh charge step |
| rf_sense | input | 1 | Refresh sense step |
| rf_restore | input | 1 | Refresh write-back step |
| ac_pre | input | 1 | Access charge step |
| ac_sense | input | 1 | Access sense step; latches the command inputs |
| ac_drive | input | 1 | Access read-out step |
| ac_commit | input | 1 | Access write-back step |
| chr_addr | input | 4 | Main row (character) number |
| stat_sel | input | 1 | 1 selects a status row |
| stat_idx | input | 2 | Status row number |
| reg_sel | input | 2 | Register (nibble) number |
| rd_cmd | input | 1 | Access is a read |
| wr_cmd | input | 1 | Access is a write |
| bus_in | input | 4 | Write data from the bus |
| rd_data | output | 4 | Read nibble |
| rd_oe | output | 1 | Read output enable |

## Verification
Reset and a write commit can meet in the same access: reset blocks sensing, while the commit still rewrites the addressed row. The bench provokes this by running a full write access, with a non-zero bus value, while `rst` is held. After release it reads the row back and expects zeros in all four nibbles, not the bus value. It also confirms that a status row the access did not touch still holds its data, and that `rd_oe` stayed low throughout.

// File: rtl/drf_pkg.sv
package drf_pkg;

    // Default geometry, shared by the top and its children.
    localparam int unsigned CHR_W_D     = 4;
    localparam int unsigned NREG_D      = 4;
    localparam int unsigned MAIN_ROWS_D = 16;
    localparam int unsigned STAT_ROWS_D = 4;
    localparam int unsigned CNT_W_D     = 5;

    // Position within a charge/sense/write-back sequence.
    typedef enum logic [2:0] {
        S_IDLE,
        S_RF_PRE,
        S_RF_SENSED,
        S_AC_PRE,
        S_AC_SENSED,
        S_AC_DRIVEN
    } seq_state_e;

    // Per-cycle actions issued by the sequencer.
    typedef struct packed {
        logic pre;     // charge column lines
        logic rf_ld;   // sense refresh row
        logic rf_wb;   // write refresh row back
        logic ac_ld;   // sense access row, latch command
        logic ac_out;  // read-out window
        logic ac_wb;   // access write-back window
    } seq_ctl_t;

endpackage

// File: rtl/drf_seq_fsm.sv
module drf_seq_fsm
    import drf_pkg::*;
(
    input  logic       clk,
    input  logic       rf_pre,
    input  logic       rf_sense,
    input  logic       rf_restore,
    input  logic       ac_pre,
    input  logic       ac_sense,
    input  logic       ac_drive,
    input  logic       ac_commit,
    output seq_state_e state_o,
    output seq_ctl_t   ctl_o
);

    // No reset on purpose: refresh must keep running while rst is high.
    seq_state_e state_q = S_IDLE;
    seq_state_e state_d;
    logic       any_stb;

    assign any_stb = rf_pre | rf_sense | rf_restore |
                     ac_pre | ac_sense | ac_drive | ac_commit;

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (rf_pre) begin
            state_d = S_RF_PRE;
        end else if (ac_pre) begin
            state_d = S_AC_PRE;
        end else begin
            unique case (state_q)
                S_IDLE:      state_d = S_IDLE;
                S_RF_PRE:    if (rf_sense) state_d = S_RF_SENSED;
                             else if (any_stb) state_d = S_IDLE;
                S_RF_SENSED: if (any_stb) state_d = S_IDLE;
                S_AC_PRE:    if (ac_sense) state_d = S_AC_SENSED;
                             else if (any_stb) state_d = S_IDLE;
                S_AC_SENSED: if (ac_drive) state_d = S_AC_DRIVEN;
                             else if (any_stb) state_d = S_IDLE;
                S_AC_DRIVEN: if (any_stb) state_d = S_IDLE;
                default:     state_d = S_IDLE;
            endcase
        end
    end

    always_comb begin
        ctl_o     = '0;
        ctl_o.pre = rf_pre | ac_pre;
        unique case (state_q)
            S_RF_PRE:    ctl_o.rf_ld  = rf_sense;
            S_RF_SENSED: ctl_o.rf_wb  = rf_restore;
            S_AC_PRE:    ctl_o.ac_ld  = ac_sense;
            S_AC_SENSED: begin
                ctl_o.ac_out = ac_drive;
                ctl_o.ac_wb  = ac_commit;
            end
            S_AC_DRIVEN: ctl_o.ac_wb  = ac_commit;
            default:     ctl_o        = ctl_o;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/drf_row_sel.sv
module drf_row_sel #(
    parameter int unsigned MAIN_ROWS = 16,
    parameter int unsigned STAT_ROWS = 4,
    parameter int unsigned CNT_W     = 5,
    parameter int unsigned CHR_AW    = $clog2(MAIN_ROWS),
    parameter int unsigned STAT_AW   = $clog2(STAT_ROWS),
    parameter int unsigned ROW_AW    = $clog2(MAIN_ROWS + STAT_ROWS)
) (
    input  logic               clk,
    input  logic               step,
    input  logic [CHR_AW-1:0]  chr_addr,
    input  logic               stat_sel,
    input  logic [STAT_AW-1:0] stat_idx,
    output logic [CNT_W-1:0]   cnt_o,
    output logic [ROW_AW-1:0]  rf_row,
    output logic [ROW_AW-1:0]  ac_row
);

    // Free-running down counter; advances once per refresh write-back.
    logic [CNT_W-1:0] cnt_q = '1;

    always_ff @(posedge clk) begin
        if (step) cnt_q <= cnt_q - CNT_W'(1);
    end

    // Top bit picks status space; only the low bits index a status row.
    assign rf_row = cnt_q[CNT_W-1]
                  ? ROW_AW'(MAIN_ROWS) + ROW_AW'(cnt_q[STAT_AW-1:0])
                  : ROW_AW'(cnt_q[CHR_AW-1:0]);

    assign ac_row = stat_sel
                  ? ROW_AW'(MAIN_ROWS) + ROW_AW'(stat_idx)
                  : ROW_AW'(chr_addr);

    assign cnt_o = cnt_q;

endmodule

// File: rtl/drf_cell_array.sv
module drf_cell_array
    import drf_pkg::*;
#(
    parameter int unsigned CHR_W  = 4,
    parameter int unsigned NREG   = 4,
    parameter int unsigned NROWS  = 20,
    parameter int unsigned ROW_AW = $clog2(NROWS),
    parameter int unsigned RSEL_W = $clog2(NREG),
    parameter int unsigned ROW_W  = CHR_W * NREG
) (
    input  logic              clk,
    input  logic              rst,
    input  seq_ctl_t          ctl,
    input  logic [ROW_AW-1:0] rf_row,
    input  logic [ROW_AW-1:0] ac_row,
    input  logic [RSEL_W-1:0] reg_sel,
    input  logic              rd_cmd,
    input  logic              wr_cmd,
    input  logic [CHR_W-1:0]  bus_in,
    output logic [CHR_W-1:0]  rd_nib,
    output logic              rd_lat
);

    // Cells hold line levels: a charged (1) line stands for logic 0.
    logic [ROW_W-1:0]  cells [NROWS];
    logic [ROW_W-1:0]  sense_q = '1;
    logic [ROW_W-1:0]  wb_row;
    logic [ROW_AW-1:0] ld_row;
    logic [ROW_AW-1:0] row_q  = '0;
    logic [RSEL_W-1:0] reg_q  = '0;
    logic              wr_q   = 1'b0;
    logic              rd_q   = 1'b0;
    logic              wb_en;

    assign ld_row = ctl.rf_ld ? rf_row : ac_row;

    always_ff @(posedge clk) begin
        if (ctl.pre) begin
            sense_q <= '1;
        end else if ((ctl.rf_ld || ctl.ac_ld) && !rst) begin
            sense_q <= cells[ld_row];
        end
        if (ctl.rf_ld || ctl.ac_ld) row_q <= ld_row;
        if (ctl.ac_ld) begin
            reg_q <= reg_sel;
            wr_q  <= wr_cmd;
            rd_q  <= rd_cmd;
        end
    end

    // Only the latched register takes the bus, and never under reset.
    for (genvar g = 0; g < NREG; g++) begin : g_nib
        assign wb_row[g*CHR_W +: CHR_W] =
            (ctl.ac_wb && !rst && reg_q == RSEL_W'(g))
            ? ~bus_in
            : sense_q[g*CHR_W +: CHR_W];
    end

    assign wb_en = ctl.rf_wb || (ctl.ac_wb && wr_q);

    always_ff @(posedge clk) begin
        if (wb_en) cells[row_q] <= wb_row;
    end

    assign rd_nib = ~sense_q[reg_q*CHR_W +: CHR_W];
    assign rd_lat = rd_q;

endmodule

// File: rtl/drf_refresh_seq.sv
module drf_refresh_seq
    import drf_pkg::*;
#(
    parameter int unsigned CHR_W     = CHR_W_D,
    parameter int unsigned NREG      = NREG_D,
    parameter int unsigned MAIN_ROWS = MAIN_ROWS_D,
    parameter int unsigned STAT_ROWS = STAT_ROWS_D,
    parameter int unsigned CNT_W     = CNT_W_D,
    localparam int unsigned CHR_AW   = $clog2(MAIN_ROWS),
    localparam int unsigned STAT_AW  = $clog2(STAT_ROWS),
    localparam int unsigned RSEL_W   = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rf_pre,
    input  logic               rf_sense,
    input  logic               rf_restore,
    input  logic               ac_pre,
    input  logic               ac_sense,
    input  logic               ac_drive,
    input  logic               ac_commit,
    input  logic [CHR_AW-1:0]  chr_addr,
    input  logic               stat_sel,
    input  logic [STAT_AW-1:0] stat_idx,
    input  logic [RSEL_W-1:0]  reg_sel,
    input  logic               rd_cmd,
    input  logic               wr_cmd,
    input  logic [CHR_W-1:0]   bus_in,
    output logic [CHR_W-1:0]   rd_data,
    output logic               rd_oe
);

    localparam int unsigned NROWS  = MAIN_ROWS + STAT_ROWS;
    localparam int unsigned ROW_AW = $clog2(NROWS);

    seq_state_e        state_w;
    seq_ctl_t          ctl_w;
    logic [CNT_W-1:0]  cnt_w;
    logic [ROW_AW-1:0] rf_row_w;
    logic [ROW_AW-1:0] ac_row_w;
    logic [CHR_W-1:0]  nib_w;
    logic              rd_lat_w;

    drf_seq_fsm u_fsm (
        .clk        (clk),
        .rf_pre     (rf_pre),
        .rf_sense   (rf_sense),
        .rf_restore (rf_restore),
        .ac_pre     (ac_pre),
        .ac_sense   (ac_sense),
        .ac_drive   (ac_drive),
        .ac_commit  (ac_commit),
        .state_o    (state_w),
        .ctl_o      (ctl_w)
    );

    drf_row_sel #(
        .MAIN_ROWS (MAIN_ROWS),
        .STAT_ROWS (STAT_ROWS),
        .CNT_W     (CNT_W),
        .CHR_AW    (CHR_AW),
        .STAT_AW   (STAT_AW),
        .ROW_AW    (ROW_AW)
    ) u_rows (
        .clk      (clk),
        .step     (ctl_w.rf_wb),
        .chr_addr (chr_addr),
        .stat_sel (stat_sel),
        .stat_idx (stat_idx),
        .cnt_o    (cnt_w),
        .rf_row   (rf_row_w),
        .ac_row   (ac_row_w)
    );

    drf_cell_array #(
        .CHR_W  (CHR_W),
        .NREG   (NREG),
        .NROWS  (NROWS),
        .ROW_AW (ROW_AW),
        .RSEL_W (RSEL_W)
    ) u_cells (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl_w),
        .rf_row  (rf_row_w),
        .ac_row  (ac_row_w),
        .reg_sel (reg_sel),
        .rd_cmd  (rd_cmd),
        .wr_cmd  (wr_cmd),
        .bus_in  (bus_in),
        .rd_nib  (nib_w),
        .rd_lat  (rd_lat_w)
    );

    assign rd_oe   = ctl_w.ac_out && rd_lat_w && !rst;
    assign rd_data = rd_oe ? nib_w : '0;

endmodule

// File: rtl/drf_refresh_seq_chk.sv
module drf_refresh_seq_chk
    import drf_pkg::*;
#(
    parameter int unsigned CNT_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic [6:0]       stb,
    input logic             rd_oe,
    input seq_ctl_t         ctl,
    input logic [CNT_W-1:0] cnt
);

    // stb order: rf_pre, rf_sense, rf_restore, ac_pre, ac_sense, ac_drive, ac_commit
    a_r1_onehot_strobes: assert property (@(posedge clk) disable iff (rst)
        $onehot0(stb));

    a_r2_count_down: assert property (@(posedge clk) disable iff (rst)
        ctl.rf_wb |=> (cnt == $past(cnt) - CNT_W'(1)));

    a_r2_count_hold: assert property (@(posedge clk) disable iff (rst)
        !ctl.rf_wb |=> $stable(cnt));

    a_r4_oe_in_drive: assert property (@(posedge clk) disable iff (rst)
        rd_oe |-> stb[1]);

    a_r8_oe_after_sense: assert property (@(posedge clk) disable iff (rst)
        rd_oe |-> $past(stb[2]));

    a_r8_wb_after_sense: assert property (@(posedge clk) disable iff (rst)
        ctl.rf_wb |-> $past(stb[5]));

    always_comb begin
        if (rst) begin
            a_r7_no_oe_in_reset: assert (!rd_oe);
        end
    end

endmodule

bind drf_refresh_seq drf_refresh_seq_chk #(
    .CNT_W (CNT_W)
) u_chk (
    .clk   (clk),
    .rst   (rst),
    .stb   ({rf_pre, rf_sense, rf_restore, ac_pre, ac_sense, ac_drive, ac_commit}),
    .rd_oe (rd_oe),
    .ctl   (ctl_w),
    .cnt   (cnt_w)
);

// File: tb/drf_refresh_seq_tb_top.sv
module drf_refresh_seq_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rf_pre = 0, rf_sense = 0, rf_restore = 0;
    logic       ac_pre = 0, ac_sense = 0, ac_drive = 0, ac_commit = 0;
    logic [3:0] chr_addr = '0;
    logic       stat_sel = 1'b0;
    logic [1:0] stat_idx = '0;
    logic [1:0] reg_sel = '0;
    logic       rd_cmd = 1'b0, wr_cmd = 1'b0;
    logic [3:0] bus_in = '0;
    logic [3:0] rd_data;
    logic       rd_oe;

    always #10 clk = ~clk;

    drf_refresh_seq dut_i (
        .clk(clk), .rst(rst),
        .rf_pre(rf_pre), .rf_sense(rf_sense), .rf_restore(rf_restore),
        .ac_pre(ac_pre), .ac_sense(ac_sense), .ac_drive(ac_drive),
        .ac_commit(ac_commit),
        .chr_addr(chr_addr), .stat_sel(stat_sel), .stat_idx(stat_idx),
        .reg_sel(reg_sel), .rd_cmd(rd_cmd), .wr_cmd(wr_cmd),
        .bus_in(bus_in), .rd_data(rd_data), .rd_oe(rd_oe)
    );

    localparam logic [6:0] K_NONE = 7'b0000000;
    localparam logic [6:0] K_RFP  = 7'b1000000;
    localparam logic [6:0] K_RFS  = 7'b0100000;
    localparam logic [6:0] K_RFR  = 7'b0010000;
    localparam logic [6:0] K_ACP  = 7'b0001000;
    localparam logic [6:0] K_ACS  = 7'b0000100;
    localparam logic [6:0] K_ACD  = 7'b0000010;
    localparam logic [6:0] K_ACC  = 7'b0000001;

    int         n_chk  = 0;
    int         n_fail = 0;
    logic [3:0] mdl [20][4];
    logic [3:0] exp_q [$];
    string      tag_q [$];

    task automatic check(string tag, logic [7:0] act, logic [7:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic tick(logic [6:0] k);
        @(posedge clk);
        #1;
        {rf_pre, rf_sense, rf_restore, ac_pre, ac_sense, ac_drive, ac_commit} = k;
    endtask

    task automatic refresh_step();
        tick(K_RFP); tick(K_RFS); tick(K_RFR); tick(K_NONE);
    endtask

    // Scoreboard driver: one access; reads push expectations for the monitor.
    task automatic access(bit st, int idx, int rg, bit rd, bit wr,
                          logic [3:0] d, int rg_late, string tag);
        int row;
        row = st ? 16 + (idx % 4) : idx;
        tick(K_ACP);
        tick(K_ACS);
        stat_sel = st;
        stat_idx = 2'(idx);
        chr_addr = st ? 4'h9 : 4'(idx);
        reg_sel  = 2'(rg);
        rd_cmd   = rd;
        wr_cmd   = wr;
        bus_in   = d;
        if (rd && !rst) begin
            exp_q.push_back(mdl[row][rg]);
            tag_q.push_back(tag);
        end
        tick(K_ACD);
        if (rg_late >= 0) begin
            reg_sel  = 2'(rg_late);
            chr_addr = chr_addr + 4'd1;
        end
        @(negedge clk);
        if (!rd || rst) check({tag, " no read enable"}, {7'd0, rd_oe}, 8'd0);
        tick(K_ACC);
        tick(K_NONE);
        rd_cmd = 1'b0;
        wr_cmd = 1'b0;
        if (wr) begin
            if (rst) for (int g = 0; g < 4; g++) mdl[row][g] = 4'h0;
            else     mdl[row][rg] = d;
        end
    endtask

    task automatic read_all(string tag);
        for (int r = 0; r < 20; r++)
            for (int g = 0; g < 4; g++)
                access(r >= 16, (r >= 16) ? r - 16 : r, g, 1, 0, 4'h0, -1, tag);
    endtask

    task automatic clear_model();
        for (int r = 0; r < 20; r++)
            for (int g = 0; g < 4; g++) mdl[r][g] = 4'h0;
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rd_oe) begin
            if (exp_q.size() == 0) begin
                check("R4 unexpected read enable", 8'd1, 8'd0);
            end else begin
                check(tag_q.pop_front(), {4'd0, rd_data}, {4'd0, exp_q.pop_front()});
            end
        end
    end

    bit done = 1'b0;

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        clear_model();
        tick(K_NONE); tick(K_NONE);
        @(negedge clk);
        check("R7 reset oe", {7'd0, rd_oe}, 8'd0);
        check("R4 reset data", {4'd0, rd_data}, 8'd0);

        // R6: clear under reset
        for (int i = 0; i < 32; i++) refresh_step();
        rst = 1'b0;
        tick(K_NONE);
        read_all("R6 cleared after reset refresh");

        // R5 / R4: fill a row, then overwrite one nibble
        for (int g = 0; g < 4; g++) access(0, 3, g, 0, 1, 4'(g + 1), -1, "R5 fill");
        access(0, 3, 2, 0, 1, 4'hA, -1, "R5 overwrite");
        for (int g = 0; g < 4; g++) access(0, 3, g, 1, 0, 4'h0, -1, "R5 neighbours kept");
        access(0, 3, 1, 0, 0, 4'h0, -1, "R4 no-command access");

        // R3: status addressing ignores chr_addr
        access(1, 1, 0, 0, 1, 4'h7, -1, "R3 status write");
        access(0, 1, 0, 1, 0, 4'h0, -1, "R3 main row untouched");
        access(1, 1, 0, 1, 0, 4'h0, -1, "R3 status read");
        access(1, 2, 0, 1, 0, 4'h0, -1, "R3 other status row");

        // R2: retention across more than a full counter pass
        for (int i = 0; i < 40; i++) refresh_step();
        for (int g = 0; g < 4; g++) access(0, 3, g, 1, 0, 4'h0, -1, "R2 retained main");
        access(1, 1, 0, 1, 0, 4'h0, -1, "R2 retained status");

        // R9: late change of reg_sel / chr_addr has no effect
        access(0, 5, 1, 0, 1, 4'h6, 3, "R9 late change");
        for (int g = 0; g < 4; g++) access(0, 5, g, 1, 0, 4'h0, -1, "R9 latched target");

        // R8: write-back without a sense step does nothing
        tick(K_ACP);
        wr_cmd = 1'b1; bus_in = 4'hF; stat_sel = 1'b0; chr_addr = 4'd5; reg_sel = 2'd1;
        tick(K_ACC);
        tick(K_NONE);
        wr_cmd = 1'b0;
        tick(K_RFP); tick(K_RFR); tick(K_NONE);
        read_all("R8 unsensed write-back ignored");

        // R7: write commit under reset stores zeros, never the bus value
        rst = 1'b1;
        tick(K_NONE);
        access(0, 3, 0, 1, 0, 4'h0, -1, "R7 read blocked in reset");
        access(0, 3, 0, 0, 1, 4'h9, -1, "R7 write in reset");
        rst = 1'b0;
        tick(K_NONE);
        for (int g = 0; g < 4; g++) access(0, 3, g, 1, 0, 4'h0, -1, "R7 row zeroed");
        access(1, 1, 0, 1, 0, 4'h0, -1, "R7 other row kept");

        // R6 again, over non-zero contents
        rst = 1'b1;
        for (int i = 0; i < 32; i++) refresh_step();
        rst = 1'b0;
        clear_model();
        tick(K_NONE);
        read_all("R6 second clear");

        tick(K_NONE); tick(K_NONE);
        check("R4 all reads observed", 8'(exp_q.size()), 8'd0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule